// File: doc/BRIEF.md
# Adaptive On-Time Switch Sequencer

This block produces the gate commands for the two switches of a synchronous step-down converter regulated by a constant on-time loop. Each switching period opens with a high-side pulse whose length comes from a per-option volt-time constant divided by a digitized input-voltage code. Because the divisor is the input voltage, the pulse gets shorter as the input rises, and the volt-time product stays fixed. After the pulse, a blanking interval keeps the high side off and ignores the feedback comparator, which shields the loop from switching noise. Once the blanking is over, the block waits until the comparator reports that feedback is below the reference, and then starts the next period.

The low-side switch is driven as the complement of the high side, with a guard gap of a few clocks on both edges. While the soft-start flag is set, the block drives only the high side, halves the on-time and stretches the blanking interval. This allows start-up into a prebiased output. When the enable is low, the block marks both drivers as high-impedance. A one-clock strobe marks each new period for a counter further downstream.

Top module: `aot_switch_seq`

## Requirements
- R1: While `run_en` is low, `drv_hiz` is 1 and `hs_on` and `ls_on` are 0. This takes effect from the clock edge after `run_en` falls, even in the middle of a pulse.
- R2: Outside soft-start, the `hs_on` pulse lasts T = round(A / `vin_code`) clocks, with A = 8250, 16500 or 33000 for `time_opt` codes 0, 1 and 2. Code 3 behaves like code 2. A `vin_code` of 0 gives the maximum on-time.
- R3: T is clamped to the range 40 to 1023 clocks.
- R4: Between two `hs_on` pulses, `hs_on` stays low for at least 38 clocks (152 while soft-start is set). `fb_below` is ignored during that interval. With `fb_below` held high, the low interval is exactly that length.
- R5: After the blanking interval, `hs_on` stays low and no period starts while `fb_below` is 0. A new period starts on the first clock edge at which `fb_below` is 1.
- R6: `hs_on` and `ls_on` are never high together. `ls_on` falls exactly 2 clocks before `hs_on` rises, and rises exactly 2 clocks after `hs_on` falls.
- R7: While `soft_start` is 1, `ls_on` stays 0 and the on-time is max(floor(T/2), 1) clocks.
- R8: `period_start` is a single-clock pulse, raised once per period on the edge at which the period is decided. `hs_on` rises 3 clocks later.
- R9: The on-time is latched at the start of the period. A change to `vin_code` or `time_opt` during a pulse leaves that pulse's length unchanged, and later periods pick up the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Enables switching when high |
| soft_start | input | 1 | Selects soft-start behaviour |
| fb_below | input | 1 | Comparator: feedback below reference |
| vin_code | input | VIN_W (8) | Digitized input voltage |
| time_opt | input | 2 | Timing option select |
| hs_on | output | 1 | High-side switch command |
| ls_on | output | 1 | Low-side switch command |
| drv_hiz | output | 1 | Both drivers high-impedance |
| period_start | output | 1 | One-clock strobe per new period |

## Verification
The bench drives the extreme ends of the on-time computation. A small volt-time constant with the largest input code must hit the lower clamp, and a large constant with a low code or a zero code must hit the upper clamp. A divider that rounds wrongly, or that mishandles a zero divisor, shows up as a pulse that is off by one or that runs away. The comparator is toggled at random to catch a design that lets comparator activity during blanking shorten the off-time. A mid-pulse change of the input code catches a design that does not latch the on-time and stretches or truncates the pulse in flight. Soft-start cases check that the low side stays dark and the timings are halved and stretched. Idle-comparator and mid-pulse disable cases catch stray pulses and drivers left active.

// File: rtl/aot_pkg.sv
// Shared types for the adaptive on-time switch sequencer.
// Assumes nothing beyond IEEE 1800-2017 synthesizable constructs.
package aot_pkg;

    // Phase of one switching period; PH_OFF also stands for "disabled".
    typedef enum logic [1:0] {
        PH_OFF   = 2'd0,
        PH_WAIT  = 2'd1,
        PH_ON    = 2'd2,
        PH_BLANK = 2'd3
    } phase_t;

endpackage

// File: rtl/aot_ontime_div.sv
// Computes the on-time count round(alpha / vin) with a restoring divider
// that keeps re-running, then clamps the result to [TON_MIN, TON_MAX].
// Assumes TON_W <= ALPHA_W + 1 and TON_MIN >= 1. A zero vin gives TON_MAX.
module aot_ontime_div #(
    parameter int VIN_W     = 8,
    parameter int TON_W     = 11,
    parameter int ALPHA_W   = 16,
    parameter int ALPHA_OPT0 = 8250,
    parameter int ALPHA_OPT1 = 16500,
    parameter int ALPHA_OPT2 = 33000,
    parameter int TON_MIN   = 40,
    parameter int TON_MAX   = 1023
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VIN_W-1:0] vin_code,
    input  logic [1:0]       time_opt,
    output logic [TON_W-1:0] ton_base
);
    localparam int NUM_W  = ALPHA_W + 1;
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [ALPHA_W-1:0] alpha_sel;
    logic [NUM_W-1:0]   num_init;
    logic               busy;
    logic [STEP_W-1:0]  steps;
    logic [NUM_W-1:0]   num_sh;
    logic [NUM_W-1:0]   quo;
    logic [VIN_W-1:0]   den;
    logic [VIN_W-1:0]   rem;
    logic [VIN_W:0]     trial;
    logic [VIN_W:0]     diff;
    logic               take;
    logic [VIN_W-1:0]   rem_nx;
    logic [NUM_W-1:0]   quo_nx;
    logic [TON_W-1:0]   ton_clamped;

    // Pick the volt-time constant and add half the divisor for rounding.
    always_comb begin
        case (time_opt)
            2'd0:    alpha_sel = ALPHA_W'(ALPHA_OPT0);
            2'd1:    alpha_sel = ALPHA_W'(ALPHA_OPT1);
            default: alpha_sel = ALPHA_W'(ALPHA_OPT2);
        endcase
        num_init = {1'b0, alpha_sel} + NUM_W'(vin_code >> 1);
    end

    // One restoring-division step: try to subtract the divisor.
    always_comb begin
        trial  = {rem, num_sh[NUM_W-1]};
        diff   = trial - {1'b0, den};
        take   = (trial >= {1'b0, den});
        rem_nx = take ? diff[VIN_W-1:0] : trial[VIN_W-1:0];
        quo_nx = {quo[NUM_W-2:0], take};
    end

    // Clamp the finished quotient into the allowed on-time window.
    always_comb begin
        if (quo_nx > NUM_W'(TON_MAX))
            ton_clamped = TON_W'(TON_MAX);
        else if (quo_nx < NUM_W'(TON_MIN))
            ton_clamped = TON_W'(TON_MIN);
        else
            ton_clamped = quo_nx[TON_W-1:0];
    end

    // Divider sequencing: load, iterate NUM_W steps, publish, repeat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            steps    <= '0;
            num_sh   <= '0;
            quo      <= '0;
            den      <= '0;
            rem      <= '0;
            ton_base <= TON_W'(TON_MAX);
        end else if (!busy) begin
            if (vin_code == '0) begin
                ton_base <= TON_W'(TON_MAX);
            end else begin
                busy   <= 1'b1;
                steps  <= STEP_W'(NUM_W);
                num_sh <= num_init;
                den    <= vin_code;
                rem    <= '0;
                quo    <= '0;
            end
        end else begin
            rem    <= rem_nx;
            quo    <= quo_nx;
            num_sh <= num_sh << 1;
            steps  <= steps - 1'b1;
            if (steps == STEP_W'(1)) begin
                busy     <= 1'b0;
                ton_base <= ton_clamped;
            end
        end
    end

endmodule

// File: rtl/aot_phase_ctl.sv
// Period state machine: on-time, blanking, then waiting for the comparator.
// The on-time is latched on entry to PH_ON and always runs to completion.
// Assumes ton_base >= 1 and TOFF_MIN >= 1.
module aot_phase_ctl
    import aot_pkg::*;
#(
    parameter int TON_W        = 11,
    parameter int TOFF_MIN     = 38,
    parameter int SS_TON_SHIFT = 1,
    parameter int SS_TOFF_MULT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             soft_start,
    input  logic             fb_below,
    input  logic [TON_W-1:0] ton_base,
    output logic             hs_cmd,
    output logic             active,
    output logic             period_start
);
    localparam int TOFF_SS = TOFF_MIN * SS_TOFF_MULT;
    localparam int OFF_W   = $clog2(TOFF_SS + 1);
    localparam int CNT_W   = (TON_W > OFF_W) ? TON_W : OFF_W;

    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [TON_W-1:0] ton_half;
    logic [TON_W-1:0] ton_sel;
    logic [CNT_W-1:0] ton_ld;
    logic [CNT_W-1:0] off_ld;

    // Select on-time and blanking length for the current mode.
    always_comb begin
        ton_half = ton_base >> SS_TON_SHIFT;
        if (soft_start)
            ton_sel = (ton_half == '0) ? TON_W'(1) : ton_half;
        else
            ton_sel = ton_base;
        ton_ld = CNT_W'(ton_sel) - 1'b1;
        off_ld = soft_start ? CNT_W'(TOFF_SS - 1) : CNT_W'(TOFF_MIN - 1);
    end

    // Phase register decodes.
    assign hs_cmd = (phase == PH_ON);
    assign active = (phase != PH_OFF);

    // Phase transitions, counters and the period strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_OFF;
            cnt          <= '0;
            period_start <= 1'b0;
        end else begin
            period_start <= 1'b0;
            if (!run_en) begin
                phase <= PH_OFF;
                cnt   <= '0;
            end else begin
                case (phase)
                    PH_OFF: phase <= PH_WAIT;
                    PH_WAIT: begin
                        if (fb_below) begin
                            phase        <= PH_ON;
                            cnt          <= ton_ld;
                            period_start <= 1'b1;
                        end
                    end
                    PH_ON: begin
                        if (cnt == '0) begin
                            phase <= PH_BLANK;
                            cnt   <= off_ld;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: begin
                        if (cnt != '0) begin
                            cnt <= cnt - 1'b1;
                        end else if (fb_below) begin
                            phase        <= PH_ON;
                            cnt          <= ton_ld;
                            period_start <= 1'b1;
                        end else begin
                            phase <= PH_WAIT;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/aot_deadband.sv
// Turns the raw high-side command into non-overlapping switch commands.
// The high side is the command delayed DEAD_CYC+1 clocks (width kept); the
// low side is off while any of the last 2*DEAD_CYC+1 command samples is set.
// Assumes the command is clear whenever active is low.
module aot_deadband #(
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hs_cmd,
    input  logic ls_block,
    output logic hs_on,
    output logic ls_on
);
    localparam int HW = 2 * DEAD_CYC + 1;

    logic [HW-1:0] hist;

    generate
        if (HW == 1) begin : g_single
            // History of one sample: no guard gap.
            always_ff @(posedge clk) begin
                if (!rst_n || !active) hist <= '0;
                else                   hist <= hs_cmd;
            end
        end else begin : g_chain
            // Shift the command through the guard window.
            always_ff @(posedge clk) begin
                if (!rst_n || !active) hist <= '0;
                else                   hist <= {hist[HW-2:0], hs_cmd};
            end
        end
    endgenerate

    assign hs_on = active & hist[DEAD_CYC];
    assign ls_on = active & ~ls_block & ~(|hist);

endmodule

// File: rtl/aot_switch_seq.sv
// Top of the adaptive on-time switch sequencer: on-time divider, period
// state machine and dead-band stage. Inputs are assumed synchronous to clk.
module aot_switch_seq #(
    parameter int VIN_W        = 8,
    parameter int TON_W        = 11,
    parameter int ALPHA_W      = 16,
    parameter int ALPHA_OPT0   = 8250,
    parameter int ALPHA_OPT1   = 16500,
    parameter int ALPHA_OPT2   = 33000,
    parameter int TON_MIN      = 40,
    parameter int TON_MAX      = 1023,
    parameter int TOFF_MIN     = 38,
    parameter int SS_TON_SHIFT = 1,
    parameter int SS_TOFF_MULT = 4,
    parameter int DEAD_CYC     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             soft_start,
    input  logic             fb_below,
    input  logic [VIN_W-1:0] vin_code,
    input  logic [1:0]       time_opt,
    output logic             hs_on,
    output logic             ls_on,
    output logic             drv_hiz,
    output logic             period_start
);
    logic [TON_W-1:0] ton_base;
    logic             hs_cmd;
    logic             active;

    aot_ontime_div #(
        .VIN_W(VIN_W), .TON_W(TON_W), .ALPHA_W(ALPHA_W),
        .ALPHA_OPT0(ALPHA_OPT0), .ALPHA_OPT1(ALPHA_OPT1), .ALPHA_OPT2(ALPHA_OPT2),
        .TON_MIN(TON_MIN), .TON_MAX(TON_MAX)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .vin_code(vin_code),
        .time_opt(time_opt), .ton_base(ton_base)
    );

    aot_phase_ctl #(
        .TON_W(TON_W), .TOFF_MIN(TOFF_MIN),
        .SS_TON_SHIFT(SS_TON_SHIFT), .SS_TOFF_MULT(SS_TOFF_MULT)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .soft_start(soft_start),
        .fb_below(fb_below), .ton_base(ton_base), .hs_cmd(hs_cmd),
        .active(active), .period_start(period_start)
    );

    aot_deadband #(
        .DEAD_CYC(DEAD_CYC)
    ) u_dead (
        .clk(clk), .rst_n(rst_n), .active(active), .hs_cmd(hs_cmd),
        .ls_block(soft_start), .hs_on(hs_on), .ls_on(ls_on)
    );

    assign drv_hiz = ~active;

endmodule

// File: rtl/aot_seq_checker.sv
// Protocol checks on the sequencer ports; attached by bind below.
module aot_seq_checker #(
    parameter int TOFF_MIN = 38
) (
    input logic clk,
    input logic rst_n,
    input logic run_en,
    input logic soft_start,
    input logic hs_on,
    input logic ls_on,
    input logic drv_hiz,
    input logic period_start
);
    logic [15:0] lo_run;
    logic        hs_prev;
    logic        seen_fall;

    // Track how long the high side has been low since its last fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_run    <= '0;
            hs_prev   <= 1'b0;
            seen_fall <= 1'b0;
        end else begin
            hs_prev <= hs_on;
            if (hs_on)                lo_run <= '0;
            else if (lo_run != '1)    lo_run <= lo_run + 1'b1;
            if (drv_hiz)              seen_fall <= 1'b0;
            else if (hs_prev && !hs_on) seen_fall <= 1'b1;
        end
    end

    assert_hiz_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        drv_hiz |-> (!hs_on && !ls_on));
    assert_off_follows_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> drv_hiz);
    assert_min_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on && !hs_prev && seen_fall) |-> (lo_run >= 16'(TOFF_MIN)));
    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));
    assert_gap_before_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> !$past(ls_on));
    assert_ss_low_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_start |-> !ls_on);
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);
    assert_strobe_leads_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> !hs_on);

endmodule

bind aot_switch_seq aot_seq_checker #(.TOFF_MIN(TOFF_MIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .soft_start(soft_start),
    .hs_on(hs_on), .ls_on(ls_on), .drv_hiz(drv_hiz), .period_start(period_start)
);

// File: tb/test_aot_switch_seq.sv
// Self-checking bench for aot_switch_seq: directed corners plus seeded random.
module test_aot_switch_seq;
    localparam int TMIN = 40;
    localparam int TMAX = 1023;
    localparam int TOFF = 38;
    localparam int DEAD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       soft_start = 1'b0;
    logic       fb_below = 1'b0;
    logic [7:0] vin_code = 8'd66;
    logic [1:0] time_opt = 2'd1;
    logic       hs_on, ls_on, drv_hiz, period_start;

    int total = 0;
    int bad = 0;
    int overlap = 0;

    always #2 clk = ~clk;

    aot_switch_seq i_aot_switch_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .soft_start(soft_start),
        .fb_below(fb_below), .vin_code(vin_code), .time_opt(time_opt),
        .hs_on(hs_on), .ls_on(ls_on), .drv_hiz(drv_hiz), .period_start(period_start)
    );

    // Count any overlap of the two switch commands (R6).
    always @(negedge clk) if (rst_n && hs_on && ls_on) overlap++;

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int alpha_of(input int opt);
        if (opt == 0) return 8250;
        if (opt == 1) return 16500;
        return 33000;
    endfunction

    function automatic int exp_ton(input int opt, input int vin, input bit ss);
        int t;
        if (vin == 0) t = TMAX;
        else t = (alpha_of(opt) + vin / 2) / vin;
        if (t > TMAX) t = TMAX;
        if (t < TMIN) t = TMIN;
        if (ss) begin
            t = t / 2;
            if (t == 0) t = 1;
        end
        return t;
    endfunction

    task automatic drive_tick();
        @(posedge clk);
        #1;
    endtask

    // Measure one high pulse and the low gap after it, with guard gaps.
    task automatic meas(output int hi, output int lo, output int pre,
                        output int post, output int ls_seen);
        int t;
        t = 0; pre = 0; post = -1; ls_seen = 0;
        @(negedge clk);
        while (hs_on && t < 6000) begin @(negedge clk); t++; end
        while (!hs_on && t < 6000) begin
            if (ls_on) begin pre = 0; ls_seen = 1; end else pre++;
            @(negedge clk); t++;
        end
        hi = 0;
        while (hs_on && t < 6000) begin
            hi++; if (ls_on) ls_seen = 1;
            @(negedge clk); t++;
        end
        lo = 0;
        while (!hs_on && t < 6000) begin
            if (ls_on) begin ls_seen = 1; if (post < 0) post = lo; end
            lo++;
            @(negedge clk); t++;
        end
        if (t >= 6000) begin hi = -1; lo = -1; end
    endtask

    task automatic stop_and_check_hiz();
        drive_tick();
        run_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 hiz after disable", drv_hiz && !hs_on && !ls_on, drv_hiz, 1);
    endtask

    task automatic run_case(input int opt, input int vin, input bit ss, input string req);
        int hi, lo, pre, post, lss, et, eo;
        drive_tick();
        run_en = 1'b0; time_opt = 2'(opt); vin_code = 8'(vin);
        soft_start = ss; fb_below = 1'b1;
        repeat (60) @(posedge clk);
        #1 run_en = 1'b1;
        meas(hi, lo, pre, post, lss);
        et = exp_ton(opt, vin, ss);
        eo = ss ? TOFF * 4 : TOFF;
        chk(ss ? {req, " R7 ss on-time"} : {req, " on-time"}, hi == et, hi, et);
        chk(ss ? "R7 ss off-time" : "R4 off-time", lo == eo, lo, eo);
        if (ss) begin
            chk("R7 low side dark", lss == 0, lss, 0);
        end else begin
            chk("R6 gap before high", pre == DEAD, pre, DEAD);
            chk("R6 gap after high", post == DEAD, post, DEAD);
        end
        stop_and_check_hiz();
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hi, lo, pre, post, lss, cnt_hs, cnt_ps, lat;
        void'($urandom(32'd4242));
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset hiz", drv_hiz == 1'b1, drv_hiz, 1);
        chk("R1 reset quiet", !hs_on && !ls_on && !period_start, hs_on + ls_on, 0);

        // Directed corners.
        run_case(1, 66, 1'b0, "R2 nominal");
        run_case(3, 132, 1'b0, "R2 code3");
        run_case(1, 0, 1'b0, "R2 zero vin");
        run_case(0, 255, 1'b0, "R3 min clamp");
        run_case(2, 20, 1'b0, "R3 max clamp");
        run_case(2, 66, 1'b1, "R7");
        run_case(0, 255, 1'b1, "R7 min");

        // Seeded random operating points.
        for (int k = 0; k < 10; k++) begin
            run_case(int'($urandom % 4), 20 + int'($urandom % 236),
                     1'($urandom % 2), "R2 random");
        end

        // R5 and R8: idle comparator, then release.
        drive_tick();
        time_opt = 2'd1; vin_code = 8'd66; soft_start = 1'b0; fb_below = 1'b0;
        repeat (60) @(posedge clk);
        #1 run_en = 1'b1;
        cnt_hs = 0; cnt_ps = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (hs_on) cnt_hs++;
            if (period_start) cnt_ps++;
        end
        chk("R5 no pulse while fb idle", cnt_hs == 0 && cnt_ps == 0, cnt_hs + cnt_ps, 0);
        drive_tick();
        fb_below = 1'b1;
        @(negedge clk);
        chk("R8 no early strobe", period_start == 1'b0, period_start, 0);
        @(negedge clk);
        chk("R5 R8 strobe on fb", period_start == 1'b1, period_start, 1);
        lat = 0;
        while (!hs_on && lat < 20) begin @(negedge clk); lat++; end
        chk("R8 strobe to high side", lat == DEAD + 1, lat, DEAD + 1);
        chk("R8 strobe single", period_start == 1'b0, period_start, 0);
        stop_and_check_hiz();

        // R4: random comparator activity; off-time never below the minimum.
        drive_tick();
        time_opt = 2'd1; vin_code = 8'd100; soft_start = 1'b0; fb_below = 1'b1;
        repeat (60) @(posedge clk);
        #1 run_en = 1'b1;
        fork
            begin
                for (int i = 0; i < 5000; i++) begin
                    @(posedge clk); #1 fb_below = (($urandom % 4) != 0);
                end
            end
            begin
                int hr, lr; bit rose, prev;
                hr = 0; lr = 0; rose = 0; prev = 0;
                for (int i = 0; i < 5000; i++) begin
                    @(negedge clk);
                    if (hs_on) begin
                        if (!prev) begin
                            if (rose) chk("R4 min off with random fb", lr >= TOFF, lr, TOFF);
                            rose = 1;
                        end
                        hr++; lr = 0;
                    end else begin
                        if (prev && rose) chk("R2 on-time with random fb", hr == 165, hr, 165);
                        lr++; hr = 0;
                    end
                    prev = hs_on;
                end
            end
        join
        stop_and_check_hiz();

        // R9: input change mid-pulse keeps the running pulse, later pulses update.
        drive_tick();
        time_opt = 2'd1; vin_code = 8'd66; fb_below = 1'b1;
        repeat (60) @(posedge clk);
        #1 run_en = 1'b1;
        lat = 0;
        @(negedge clk);
        while (!hs_on && lat < 2000) begin @(negedge clk); lat++; end
        hi = 1;
        drive_tick();
        vin_code = 8'd50; time_opt = 2'd0;
        @(negedge clk);
        while (hs_on && hi < 3000) begin hi++; @(negedge clk); end
        chk("R9 pulse latched", hi == 250, hi, 250);
        repeat (400) @(posedge clk);
        meas(hi, lo, pre, post, lss);
        chk("R9 new value later", hi == 165, hi, 165);

        // R1: disable in the middle of a pulse.
        @(negedge clk);
        while (!hs_on) @(negedge clk);
        stop_and_check_hiz();

        chk("R6 never overlap", overlap == 0, overlap, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule